// File: doc/BRIEF.md
# Floating-Point Exception Trap Logic

This block sits behind a floating-point execution pipe. When an instruction completes, it presents the five IEEE exception flags that instruction produced, plus the number of the register the result was written to. The block then decides whether an arithmetic trap must be taken. It builds the summary code that the trap handler reads, and it records which destination registers were involved in trapping instructions.

Each instruction selects one of two policies. Under the plain IEEE policy, any raised flag traps, and the enable mask plays no part. Under the software-completion policy, every raised flag is first merged into a sticky status register. Only flags not disabled by the per-flag mask then cause a trap, and only those flags appear in the summary code.

Each trap sets the bit for the destination register in a 64-bit write mask. That mask accumulates until it is cleared. A synchronous clear input empties both the sticky status register and the write mask.

Top module: `fpx_trap_unit`

## Requirements
- R1: After synchronous reset, `trap_o` is 0 and `code_o`, `sticky_o` and `regmask_o` are all zero.
- R2: The flag bits in `flags_i` and `mask_i` are ordered [4]=invalid, [3]=divide-by-zero, [2]=overflow, [1]=underflow, [0]=inexact. The summary code `code_o` uses the reverse order: [0]=invalid, [1]=divide-by-zero, [2]=overflow, [3]=underflow, [4]=inexact.
- R3: An accepted operation with all flags zero raises no trap, and leaves `sticky_o` and `regmask_o` unchanged.
- R4: With `swc_i`=0, any nonzero flag set traps. `code_o` then carries every raised flag, whatever `mask_i` holds, and `sticky_o` is not changed.
- R5: With `swc_i`=1, all raised flags are ORed into `sticky_o`, including flags that are masked.
- R6: With `swc_i`=1, the surviving flags are `flags_i & ~mask_i`. A trap is raised only if some flag survives, and `code_o` holds only the surviving flags.
- R7: On each trap, bit `reg_i` of `regmask_o` is set and bits already set stay set. An operation that does not trap leaves `regmask_o` unchanged.
- R8: `trap_o` is a one-cycle pulse, registered in the cycle after the accepted operation. `code_o` is valid alongside it and reads zero whenever `trap_o` is low.
- R9: `clr_i` zeroes `sticky_o` and `regmask_o` at the next edge, and takes priority over any update in the same cycle. The trap pulse of an operation accepted in that same cycle is still produced.
- R10: With `valid_i` low, the flag, register, mode and mask inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of sticky status and register mask |
| valid_i | input | 1 | An instruction's flags are presented this cycle |
| flags_i | input | 5 | Raised IEEE flags (order in R2) |
| reg_i | input | 6 | Destination register number |
| swc_i | input | 1 | 1 = software-completion policy, 0 = plain IEEE policy |
| mask_i | input | 5 | Per-flag trap disable, used only when swc_i=1 |
| trap_o | output | 1 | Arithmetic trap pulse |
| code_o | output | 5 | Trap summary code (order in R2) |
| sticky_o | output | 5 | Sticky exception status (flag order) |
| regmask_o | output | 64 | Accumulated destination-register write mask |

## Verification
Single-flag operations are run in both policies, with every mask bit set and then cleared. These tell the flag-to-summary bit reversal apart from a straight copy, and show whether the mask is wrongly applied under the plain policy. In fully masked software-completion operations, the sticky status changes while no trap fires, which separates status accumulation from trap filtering. Operations with zero flags, cycles with `valid_i` low, and a clear arriving with an operation in the same cycle test the no-effect and priority rules. Random mixes of policy, mask, flags and register then exercise OR accumulation in the register mask.

// File: rtl/fpx_trap_pkg.sv
package fpx_trap_pkg;

    // Flag vector as presented by the pipe (invalid is the MSB).
    typedef struct packed {
        logic inv;
        logic dz;
        logic ovf;
        logic unf;
        logic ine;
    } fpx_flags_t;

    // Summary code as read by the trap handler (invalid is the LSB).
    typedef struct packed {
        logic ine;
        logic unf;
        logic ovf;
        logic dz;
        logic inv;
    } fpx_sum_t;

    typedef enum logic {
        POL_PLAIN = 1'b0,
        POL_SWC   = 1'b1
    } fpx_policy_e;

    typedef struct packed {
        logic     fire;
        fpx_sum_t code;
    } fpx_trap_t;

    localparam int FPX_NFLAG = $bits(fpx_flags_t);

    function automatic fpx_sum_t fpx_to_summary(fpx_flags_t f);
        fpx_sum_t s;
        s.inv = f.inv;
        s.dz  = f.dz;
        s.ovf = f.ovf;
        s.unf = f.unf;
        s.ine = f.ine;
        return s;
    endfunction

endpackage

// File: rtl/fpx_flag_filter.sv
module fpx_flag_filter
    import fpx_trap_pkg::*;
(
    input  logic        valid_i,
    input  fpx_flags_t  flags_i,
    input  fpx_policy_e policy_i,
    input  fpx_flags_t  mask_i,
    output fpx_flags_t  survive_o,
    output logic        fire_o,
    output logic        accum_o
);
    fpx_flags_t gated;

    always_comb begin
        gated = valid_i ? flags_i : '0;
        if (policy_i == POL_SWC) begin
            survive_o = gated & ~mask_i;
        end else begin
            survive_o = gated;
        end
        fire_o  = |survive_o;
        accum_o = (policy_i == POL_SWC) && (|gated);
    end
endmodule

// File: rtl/fpx_sticky_status.sv
module fpx_sticky_status
    import fpx_trap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_i,
    input  logic       acc_i,
    input  fpx_flags_t flags_i,
    output fpx_flags_t sticky_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            sticky_o <= '0;
        end else if (acc_i) begin
            sticky_o <= sticky_o | flags_i;
        end
    end
endmodule

// File: rtl/fpx_reg_mask.sv
module fpx_reg_mask #(
    parameter int REG_W = 6,
    localparam int NREG = 1 << REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             set_i,
    input  logic [REG_W-1:0] idx_i,
    output logic [NREG-1:0]  mask_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                mask_o[g] <= 1'b0;
            end else if (set_i && (idx_i == REG_W'(g))) begin
                mask_o[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit
    import fpx_trap_pkg::*;
#(
    parameter int REG_W = 6,
    localparam int NREG = 1 << REG_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_i,
    input  logic                 valid_i,
    input  logic [FPX_NFLAG-1:0] flags_i,
    input  logic [REG_W-1:0]     reg_i,
    input  logic                 swc_i,
    input  logic [FPX_NFLAG-1:0] mask_i,
    output logic                 trap_o,
    output logic [FPX_NFLAG-1:0] code_o,
    output logic [FPX_NFLAG-1:0] sticky_o,
    output logic [NREG-1:0]      regmask_o
);
    fpx_flags_t survive;
    fpx_flags_t sticky;
    logic       fire;
    logic       accum;
    fpx_trap_t  trap_q;

    fpx_flag_filter u_filter (
        .valid_i  (valid_i),
        .flags_i  (fpx_flags_t'(flags_i)),
        .policy_i (fpx_policy_e'(swc_i)),
        .mask_i   (fpx_flags_t'(mask_i)),
        .survive_o(survive),
        .fire_o   (fire),
        .accum_o  (accum)
    );

    fpx_sticky_status u_sticky (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (clr_i),
        .acc_i   (accum),
        .flags_i (fpx_flags_t'(flags_i)),
        .sticky_o(sticky)
    );

    fpx_reg_mask #(.REG_W(REG_W)) u_regmask (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr_i),
        .set_i (fire),
        .idx_i (reg_i),
        .mask_o(regmask_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q <= '0;
        end else begin
            trap_q.fire <= fire;
            trap_q.code <= fire ? fpx_to_summary(survive) : '0;
        end
    end

    assign trap_o   = trap_q.fire;
    assign code_o   = trap_q.code;
    assign sticky_o = sticky;
endmodule

// File: rtl/fpx_trap_unit_chk.sv
module fpx_trap_unit_chk #(
    parameter int REG_W = 6,
    localparam int NREG = 1 << REG_W
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_i,
    input logic             valid_i,
    input logic [4:0]       flags_i,
    input logic [REG_W-1:0] reg_i,
    input logic             swc_i,
    input logic [4:0]       mask_i,
    input logic             trap_o,
    input logic [4:0]       code_o,
    input logic [4:0]       sticky_o,
    input logic [NREG-1:0]  regmask_o
);
    p_trap_needs_op_r8: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> ($past(valid_i) && $past(flags_i) != 5'd0 && !$past(rst)));

    p_code_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !trap_o |-> code_o == 5'd0);

    p_code_live_r6: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> code_o != 5'd0);

    p_plain_traps_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_i) && !$past(swc_i) && $past(flags_i) != 5'd0 && !$past(rst))
        |-> trap_o);

    p_quiet_op_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_i) && $past(flags_i) == 5'd0 && !$past(clr_i) && !$past(rst))
        |-> (!trap_o && $stable(sticky_o) && $stable(regmask_o)));

    p_sticky_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr_i) && !$past(rst)) |-> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

    p_regmask_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr_i) && !$past(rst)) |-> ((regmask_o & $past(regmask_o)) == $past(regmask_o)));

    p_regmask_set_r7: assert property (@(posedge clk) disable iff (rst)
        (trap_o && !$past(clr_i)) |-> regmask_o[$past(reg_i)]);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_i) && !$past(rst)) |-> (sticky_o == 5'd0 && regmask_o == '0));
endmodule

bind fpx_trap_unit fpx_trap_unit_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/test_fpx_trap_unit.sv
`timescale 1ns/1ps
module test_fpx_trap_unit;
    logic        clk = 0;
    logic        rst, clr_i, valid_i, swc_i;
    logic [4:0]  flags_i, mask_i;
    logic [5:0]  reg_i;
    logic        trap_o;
    logic [4:0]  code_o, sticky_o;
    logic [63:0] regmask_o;

    int total = 0;
    int bad   = 0;

    logic        m_trap;
    logic [4:0]  m_code, m_sticky;
    logic [63:0] m_regmask;

    always #2.5 clk = ~clk;

    fpx_trap_unit i_fpx_trap_unit (.*);

    // Flag order [4]=inv..[0]=ine ; summary order [0]=inv..[4]=ine (R2)
    function automatic logic [4:0] to_code(logic [4:0] f);
        logic [4:0] c;
        for (int k = 0; k < 5; k++) c[k] = f[4-k];
        return c;
    endfunction

    task automatic model(logic v, logic [4:0] f, logic [5:0] r, logic s, logic [4:0] m, logic c);
        logic [4:0] surv;
        surv = 5'd0;
        if (v && f != 5'd0) begin
            surv = s ? (f & ~m) : f;
            if (s) m_sticky = m_sticky | f;
            if (surv != 5'd0) m_regmask[r] = 1'b1;
        end
        m_trap = (surv != 5'd0);
        m_code = m_trap ? to_code(surv) : 5'd0;
        if (c) begin
            m_sticky  = 5'd0;
            m_regmask = 64'd0;
        end
    endtask

    task automatic check_all(string tag);
        total++;
        if (trap_o !== m_trap || code_o !== m_code ||
            sticky_o !== m_sticky || regmask_o !== m_regmask) begin
            bad++;
            $display("FAIL %s: trap=%b code=%b sticky=%b mask=%h expected trap=%b code=%b sticky=%b mask=%h",
                     tag, trap_o, code_o, sticky_o, regmask_o,
                     m_trap, m_code, m_sticky, m_regmask);
        end
    endtask

    task automatic step(string tag, logic v, logic [4:0] f, logic [5:0] r,
                        logic s, logic [4:0] m, logic c);
        valid_i = v; flags_i = f; reg_i = r; swc_i = s; mask_i = m; clr_i = c;
        @(posedge clk);
        #1;
        model(v, f, r, s, m, c);
        check_all(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        rst = 1; clr_i = 0; valid_i = 0; swc_i = 0;
        flags_i = 0; mask_i = 0; reg_i = 0;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        m_trap = 0; m_code = 0; m_sticky = 0; m_regmask = 0;
        check_all("R1 reset state");

        // R2/R4: each single flag, plain policy, full mask ignored
        for (int k = 0; k < 5; k++)
            step("R2 R4 single flag plain", 1, 5'(1 << k), 6'(k), 0, 5'h1f, 0);
        step("R8 pulse ends", 0, 5'h00, 0, 0, 0, 0);
        // R3: zero flags
        step("R3 zero flags plain", 1, 5'h00, 6'd40, 0, 0, 0);
        step("R3 zero flags swc", 1, 5'h00, 6'd41, 1, 0, 0);
        // R5/R6: fully masked swc -> sticky only
        step("R5 R6 masked swc", 1, 5'h1f, 6'd50, 1, 5'h1f, 0);
        // R6: partial mask
        step("R6 partial mask", 1, 5'h1e, 6'd51, 1, 5'h12, 0);
        step("R6 unmasked inexact", 1, 5'h01, 6'd63, 1, 5'h10, 0);
        // R10: valid low ignored
        step("R10 valid low", 0, 5'h1f, 6'd30, 0, 0, 0);
        step("R10 valid low swc", 0, 5'h1f, 6'd31, 1, 0, 0);
        // R9: clear with same-cycle op
        step("R9 clear with op", 1, 5'h08, 6'd7, 1, 5'h00, 1);
        step("R9 after clear", 0, 0, 0, 0, 0, 0);
        // R7: accumulation on same register twice and others
        step("R7 set 9", 1, 5'h04, 6'd9, 0, 0, 0);
        step("R7 set 9 again", 1, 5'h02, 6'd9, 0, 0, 0);
        step("R7 no trap keeps mask", 1, 5'h02, 6'd10, 1, 5'h02, 0);
        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step("R2 R4 R5 R6 R7 random", rv[0] | rv[1], 5'(rv[6:2] & {5{rv[7] | rv[8]}}),
                 6'(rv[14:9]), rv[15], 5'(rv[20:16]), (rv[27:21] == 7'd0));
        end
        // R1: reset mid-run
        rst = 1;
        @(posedge clk);
        #1;
        rst = 0;
        m_trap = 0; m_code = 0; m_sticky = 0; m_regmask = 0;
        check_all("R1 reset after activity");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule